// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block listens to the completed cycles of a byte-wide memory port and watches for one fixed, ordered series of six read addresses. When all six arrive in order, it asks for a restore of the nonvolatile copy into the working array. It never changes the data path. Every read to one of the key addresses still returns array data as usual. The detector only observes the address bus, the cycle strobe and the write-enable. When the last address of the series completes, it raises a request pulse for the controller that performs the restore.

Each completed cycle is marked by a one-clock strobe. A strobe with write-enable low is a read, and a strobe with write-enable high is a write. A match counter records how far into the series the reads have progressed. A read that breaks the order drops the counter back to the start. If the breaking read is itself the first key address, the counter counts it as the first step of a fresh attempt. Any write abandons the attempt, and clocks without a strobe leave the progress untouched.

Top module: `rcl_seq_detect`

## Requirements
- R1: After reset is released, `recall_req` is low. The series must then be started from its first address: a lone read of 0x0C63 gives no pulse.
- R2: Six strobed reads of the addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0C63, in that order, raise `recall_req` in the clock cycle after the strobe edge of the sixth read. None of the first five reads raises it.
- R3: `recall_req` is high for exactly one clock cycle per completed series.
- R4: A strobed read to an address other than the next expected one, and other than 0x0E38, returns progress to the start. The rest of the series read afterwards then gives no pulse.
- R5: A strobed read that breaks the order but is to 0x0E38 counts as the first step of a new series. The five following addresses then complete it and raise the pulse.
- R6: A strobed write (strobe with `wr_en` high), at any address, abandons the series in progress. The remaining reads of the series then give no pulse.
- R7: Cycles with `cyc_strobe` low do not change progress, whatever `addr` and `wr_en` carry in those cycles. A series spread over idle gaps still completes.
- R8: After a completed series, progress is back at the start. Repeating the last address, or the last five addresses, gives no second pulse.
- R9: Asserting reset in the middle of a series clears the progress made so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 15 | Address of the cycle being completed |
| cyc_strobe | input | 1 | One-clock marker of a completed memory cycle |
| wr_en | input | 1 | High when the strobed cycle is a write |
| recall_req | output | 1 | One-clock request to restore the nonvolatile copy |

## Verification
The only visible result is `recall_req`. It is registered, so it is due exactly one clock after the edge that samples the sixth read's strobe, and it is low again one clock later. The bench applies each strobe on a falling edge and holds it through one rising edge. It reads `recall_req` at the next falling edge, which is the one cycle in which a pulse caused by that read can be seen. It checks after every read of a series, so a pulse that comes early, late or twice is reported. Rules about ignored stimulus are checked the same way: the bench looks at whether the pulse appears or stays absent at the end of the series that follows the stimulus.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    localparam int unsigned ADDR_W  = 15;
    localparam int unsigned SEQ_LEN = 6;
    localparam int unsigned CNT_W   = $clog2(SEQ_LEN);

    // Key addresses, ordered as the series must arrive
    function automatic logic [ADDR_W-1:0] seq_entry(input int unsigned idx);
        logic [ADDR_W-1:0] val;
        case (idx)
            0:       val = 15'h0E38;
            1:       val = 15'h31C7;
            2:       val = 15'h03E0;
            3:       val = 15'h3C1F;
            4:       val = 15'h303F;
            5:       val = 15'h0C63;
            default: val = '0;
        endcase
        return val;
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } step_state_t;

endpackage

// File: rtl/rsd_cycle_classify.sv
module rsd_cycle_classify (
    input  logic cyc_strobe,
    input  logic wr_en,
    output logic rd_evt,
    output logic wr_evt
);

    always_comb begin
        rd_evt = cyc_strobe & ~wr_en;
        wr_evt = cyc_strobe &  wr_en;
    end

endmodule

// File: rtl/rsd_addr_match.sv
module rsd_addr_match
    import rsd_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned LEN = SEQ_LEN,
    parameter int unsigned CW  = CNT_W
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] cnt,
    output logic          hit_next,
    output logic          hit_first
);

    localparam logic [CW-1:0] LAST_IDX = CW'(LEN - 1);

    logic [LEN-1:0] hit_vec;

    // One comparator per key address
    for (genvar g = 0; g < LEN; g++) begin : g_cmp
        localparam logic [AW-1:0] KEY = AW'(seq_entry(g));
        assign hit_vec[g] = (addr == KEY);
    end

    always_comb begin
        hit_first = hit_vec[0];
        hit_next  = 1'b0;
        if (cnt <= LAST_IDX) begin
            hit_next = hit_vec[cnt];
        end
    end

endmodule

// File: rtl/rsd_step_ctrl.sv
module rsd_step_ctrl
    import rsd_pkg::*;
#(
    parameter int unsigned LEN = SEQ_LEN,
    parameter int unsigned CW  = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_evt,
    input  logic          wr_evt,
    input  logic          hit_next,
    input  logic          hit_first,
    output logic [CW-1:0] cnt,
    output logic          pulse
);

    localparam logic [CW-1:0] LAST_IDX = CW'(LEN - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    step_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_evt) begin
            st_d.cnt = '0;
        end else if (rd_evt) begin
            if (hit_next) begin
                if (st_q.cnt == LAST_IDX) begin
                    st_d.cnt   = '0;
                    st_d.pulse = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (hit_first) begin
                st_d.cnt = ONE;
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign pulse = st_q.pulse;

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    p_mismatch_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !wr_evt && !hit_next && !hit_first) |=> (cnt == '0 && !pulse));

    p_restart_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !wr_evt && !hit_next && hit_first) |=> (cnt == ONE));

    p_write_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> (cnt == '0 && !pulse));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_evt && !wr_evt) |=> ($stable(cnt) && !pulse));

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (cnt == '0));

endmodule

// File: rtl/rcl_seq_detect.sv
module rcl_seq_detect
    import rsd_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned LEN = SEQ_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cyc_strobe,
    input  logic          wr_en,
    output logic          recall_req
);

    localparam int unsigned CW = $clog2(LEN);
    localparam logic [AW-1:0] FINAL_KEY = AW'(seq_entry(LEN - 1));

    logic          rd_evt;
    logic          wr_evt;
    logic          hit_next;
    logic          hit_first;
    logic [CW-1:0] cnt;

    rsd_cycle_classify u_classify (
        .cyc_strobe (cyc_strobe),
        .wr_en      (wr_en),
        .rd_evt     (rd_evt),
        .wr_evt     (wr_evt)
    );

    rsd_addr_match #(
        .AW  (AW),
        .LEN (LEN),
        .CW  (CW)
    ) u_match (
        .addr      (addr),
        .cnt       (cnt),
        .hit_next  (hit_next),
        .hit_first (hit_first)
    );

    rsd_step_ctrl #(
        .LEN (LEN),
        .CW  (CW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_evt    (rd_evt),
        .wr_evt    (wr_evt),
        .hit_next  (hit_next),
        .hit_first (hit_first),
        .cnt       (cnt),
        .pulse     (recall_req)
    );

    // A request only ever follows a strobed read of the final key
    p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> $past(cyc_strobe && !wr_en && addr == FINAL_KEY));

    p_no_req_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && wr_en) |=> !recall_req);

endmodule

// File: tb/rcl_seq_detect_tb.sv
module rcl_seq_detect_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] addr = '0;
    logic        cyc_strobe = 1'b0;
    logic        wr_en = 1'b0;
    logic        recall_req;

    int checks = 0;
    int errors = 0;
    logic seen;

    logic [14:0] keys [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0C63};

    always #2.5 clk = ~clk;

    rcl_seq_detect u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .cyc_strobe (cyc_strobe),
        .wr_en      (wr_en),
        .recall_req (recall_req)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: recall_req actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Strobed read; returns recall_req seen one clock later
    task automatic rd(input logic [14:0] a, output logic p);
        addr = a; wr_en = 1'b0; cyc_strobe = 1'b1;
        @(negedge clk);
        cyc_strobe = 1'b0;
        addr = 15'h7FFF;
        p = recall_req;
    endtask

    task automatic wr(input logic [14:0] a);
        addr = a; wr_en = 1'b1; cyc_strobe = 1'b1;
        @(negedge clk);
        cyc_strobe = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Reads keys[from..5]; checks none before the last pulses, returns last
    task automatic tail(input int from, input string tag, output logic p);
        for (int i = from; i < 6; i++) begin
            rd(keys[i], p);
            if (i < 5) check(p, 1'b0, tag);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(recall_req, 1'b0, "R1 idle after reset");
        rd(15'h0C63, seen);
        check(seen, 1'b0, "R1 lone final key");
    endtask

    task automatic t_full();
        tail(0, "R2 early pulse", seen);
        check(seen, 1'b1, "R2 pulse after sixth read");
        @(negedge clk);
        check(recall_req, 1'b0, "R3 pulse one cycle");
    endtask

    task automatic t_out_of_order();
        tail(3, "R4 partial", seen);
        check(seen, 1'b0, "R4 tail alone");
        for (int i = 0; i < 3; i++) rd(keys[i], seen);
        rd(15'h1234, seen);
        tail(3, "R4 after break", seen);
        check(seen, 1'b0, "R4 broken series");
        rd(keys[0], seen);
        rd(keys[2], seen);
        tail(2, "R4 skipped entry", seen);
        check(seen, 1'b0, "R4 skipped entry");
        tail(0, "R4 recovery", seen);
        check(seen, 1'b1, "R4 full series after break");
    endtask

    task automatic t_restart();
        rd(keys[0], seen); rd(keys[1], seen); rd(keys[0], seen);
        tail(1, "R5 restart", seen);
        check(seen, 1'b1, "R5 restart from first key");
        rd(keys[0], seen); rd(keys[0], seen);
        tail(1, "R5 double first", seen);
        check(seen, 1'b1, "R5 repeated first key");
    endtask

    task automatic t_write_abort();
        for (int i = 0; i < 3; i++) rd(keys[i], seen);
        wr(keys[3]);
        tail(3, "R6 after write", seen);
        check(seen, 1'b0, "R6 write aborts");
        for (int i = 0; i < 5; i++) rd(keys[i], seen);
        wr(15'h0001);
        rd(keys[5], seen);
        check(seen, 1'b0, "R6 write before last");
        tail(0, "R6 recovery", seen);
        check(seen, 1'b1, "R6 series after abort");
    endtask

    task automatic t_idle();
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < 3; k++) begin
                addr = 15'h1234 + 15'(k); wr_en = k[0];
                @(negedge clk);
                check(recall_req, 1'b0, "R7 idle no pulse");
            end
            wr_en = 1'b0;
            rd(keys[i], seen);
        end
        check(seen, 1'b1, "R7 series across idle gaps");
    endtask

    task automatic t_after_done();
        tail(0, "R8 setup", seen);
        check(seen, 1'b1, "R8 setup pulse");
        rd(keys[5], seen);
        check(seen, 1'b0, "R8 final key repeated");
        tail(1, "R8 last five", seen);
        check(seen, 1'b0, "R8 last five repeated");
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 5; i++) rd(keys[i], seen);
        do_reset();
        check(recall_req, 1'b0, "R9 low after reset");
        rd(keys[5], seen);
        check(seen, 1'b0, "R9 progress cleared");
        tail(0, "R9 recovery", seen);
        check(seen, 1'b1, "R9 series after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full();
        t_out_of_order();
        t_restart();
        t_write_abort();
        t_idle();
        t_after_done();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule